// File: doc/BRIEF.md
# Chip-Wide Set/Reset Distributor

This block produces the single reset that clears or presets every user storage cell of a device, and it carries that reset to a parameterised array of model cells so its effect can be seen. The reset is held active while power-on is signalled and for the whole configuration phase, whatever the source settings are. After configuration, a programmable selector takes it from one of three places: nothing (disabled), a two-flop synchronised external reset pad, or an alternate internally routed signal. A polarity bit sets the active level of the selected source.

Each cell has a bit that picks the value it takes under reset, 1 or 0. Cells are arranged in groups, and each group has an opt-out bit that keeps the reset away from its cells once configuration is over. When the pad is asserted during configuration, it is not treated as a user reset. Instead, the block raises a one-cycle configuration-abort request. When the pad is not the selected source after configuration, its synchronised value is brought out as an ordinary input.

Everything in the block, including the outputs, is registered on one clock. Power-on works as its synchronous active-high reset.

Top module: `chip_reset_dist`

## Requirements
- R1: A rising edge that samples `por_i` or `cfg_busy_i` high sets `glob_rst_o` high right after that edge, for every value of `src_sel_i`, `src_pol_low_i`, `pad_rst_i` and `alt_rst_i`.
- R2: With `src_pol_low_i`=1 a source counts as asserted when it is 0. With `src_pol_low_i`=0 it counts as asserted when it is 1.
- R3: Outside power-on and configuration, `src_sel_i` picks the source: 0 and 3 select none (`glob_rst_o` goes low), 1 selects the pad, and 2 selects `alt_rst_i`. A change on `alt_rst_i` reaches `glob_rst_o` right after the edge that samples it.
- R4: On the edge after `glob_rst_o` was high, each cell i that is not opted out loads `cell_set_mask_i[i]`. Otherwise, on an edge where `cell_we_i[i]` is 1, cell i loads `cell_d_i[i]`. `cell_q_o` shows the cells.
- R5: Cell i belongs to group i/GRP. When bit g of `grp_optout_i` is 1, the cells of group g ignore a reset that was raised outside power-on and configuration. They keep their contents or accept writes. The opt-out has no effect on a reset raised by power-on or configuration.
- R6: `abort_pulse_o` is high for exactly one cycle. It rises on the first cycle in which configuration is active and the synchronised pad is seen asserted. It rises again only after that condition has been false for at least one edge. It is never high outside configuration.
- R7: Outside power-on and configuration, when `src_sel_i`≠1, `pad_pass_o` shows the raw synchronised pad level. In every other case it is 0.
- R8: The pad passes through two synchronising flops. A pad change reaches `glob_rst_o` on the third rising edge that samples it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on indication, active high; also the block's synchronous reset |
| cfg_busy_i | input | 1 | Configuration in progress |
| pad_rst_i | input | 1 | External reset pad, asynchronous |
| alt_rst_i | input | 1 | Alternate internally routed reset |
| src_sel_i | input | 2 | Source select: 0/3 none, 1 pad, 2 alternate |
| src_pol_low_i | input | 1 | 1: sources active low (default), 0: active high |
| cell_set_mask_i | input | NCELL | Per-cell reset value |
| grp_optout_i | input | NCELL/GRP | Per-group opt-out after configuration |
| cell_we_i | input | NCELL | Per-cell write enable |
| cell_d_i | input | NCELL | Per-cell write data |
| glob_rst_o | output | 1 | Global reset, active high internal level |
| abort_pulse_o | output | 1 | Configuration-abort request pulse |
| pad_pass_o | output | 1 | Pad value as an ordinary input |
| cell_q_o | output | NCELL | Contents of the model cells |

## Verification
Directed sequences cover four cases. Power-on and configuration are checked with the alternate source held asserted and all groups opted out, which separates the forced reset from the selected one. A pad assertion during configuration tells an abort request apart from a user reset. Pad edges after configuration are counted cycle by cycle to pin down the synchroniser depth. Both polarities are applied to the same alternate level. Random stimulus then mixes source select, polarity, opt-out masks, writes and brief configuration or power-on episodes against a cycle model. This shows whether opt-out, pass-through and abort follow the right phase.

// File: rtl/chip_rst_pkg.sv
package chip_rst_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_PAD   = 2'd1,
    SRC_ALT   = 2'd2,
    SRC_NONE2 = 2'd3
  } rst_src_e;

  // Normalise a raw level to "asserted" given the polarity bit.
  function automatic logic asserted(input logic lvl, input logic pol_low);
    return lvl ^ pol_low;
  endfunction
endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic idle_i,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= idle_i;
      sync_q <= idle_i;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
  import chip_rst_pkg::*;
(
  input  logic     clk,
  input  logic     por_i,
  input  logic     cfg_busy_i,
  input  logic     pad_sync_i,
  input  logic     alt_rst_i,
  input  rst_src_e src_sel_i,
  input  logic     pol_low_i,
  output logic     glob_q_o,
  output logic     in_cfg_q_o,
  output logic     abort_q_o,
  output logic     pass_q_o
);
  logic pad_act;
  logic alt_act;
  logic src_act;
  logic cfg_pad;
  logic cfg_pad_q;

  assign pad_act = asserted(pad_sync_i, pol_low_i);
  assign alt_act = asserted(alt_rst_i, pol_low_i);
  assign cfg_pad = cfg_busy_i & pad_act;

  always_comb begin
    unique case (src_sel_i)
      SRC_PAD: src_act = pad_act;
      SRC_ALT: src_act = alt_act;
      default: src_act = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (por_i) begin
      glob_q_o   <= 1'b1;
      in_cfg_q_o <= 1'b1;
      abort_q_o  <= 1'b0;
      cfg_pad_q  <= 1'b0;
      pass_q_o   <= 1'b0;
    end else begin
      glob_q_o   <= cfg_busy_i | src_act;
      in_cfg_q_o <= cfg_busy_i;
      abort_q_o  <= cfg_pad & ~cfg_pad_q;
      cfg_pad_q  <= cfg_pad;
      pass_q_o   <= (!cfg_busy_i && src_sel_i != SRC_PAD) ? pad_sync_i : 1'b0;
    end
  end
endmodule

// File: rtl/rst_cell_array.sv
module rst_cell_array #(
  parameter int NCELL = 16,
  parameter int GRP   = 4,
  localparam int NGRP = NCELL / GRP
) (
  input  logic             clk,
  input  logic             glob_q_i,
  input  logic             in_cfg_q_i,
  input  logic [NCELL-1:0] set_mask_i,
  input  logic [NGRP-1:0]  optout_i,
  input  logic [NCELL-1:0] we_i,
  input  logic [NCELL-1:0] d_i,
  output logic [NCELL-1:0] q_o
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic grp_rst;
    assign grp_rst = glob_q_i & (in_cfg_q_i | ~optout_i[g]);
    for (genvar c = 0; c < GRP; c++) begin : g_cell
      localparam int IDX = g * GRP + c;
      always_ff @(posedge clk) begin
        if (grp_rst)       q_o[IDX] <= set_mask_i[IDX];
        else if (we_i[IDX]) q_o[IDX] <= d_i[IDX];
      end
    end
  end
endmodule

// File: rtl/chip_reset_dist.sv
module chip_reset_dist
  import chip_rst_pkg::*;
#(
  parameter int NCELL = 16,
  parameter int GRP   = 4,
  localparam int NGRP = NCELL / GRP
) (
  input  logic             clk,
  input  logic             por_i,
  input  logic             cfg_busy_i,
  input  logic             pad_rst_i,
  input  logic             alt_rst_i,
  input  logic [1:0]       src_sel_i,
  input  logic             src_pol_low_i,
  input  logic [NCELL-1:0] cell_set_mask_i,
  input  logic [NGRP-1:0]  grp_optout_i,
  input  logic [NCELL-1:0] cell_we_i,
  input  logic [NCELL-1:0] cell_d_i,
  output logic             glob_rst_o,
  output logic             abort_pulse_o,
  output logic             pad_pass_o,
  output logic [NCELL-1:0] cell_q_o
);
  logic pad_sync;
  logic glob_q;
  logic in_cfg_q;

  rst_sync2 u_pad_sync (
    .clk    (clk),
    .rst    (por_i),
    .idle_i (src_pol_low_i),
    .d_i    (pad_rst_i),
    .q_o    (pad_sync)
  );

  rst_src_ctrl u_src (
    .clk        (clk),
    .por_i      (por_i),
    .cfg_busy_i (cfg_busy_i),
    .pad_sync_i (pad_sync),
    .alt_rst_i  (alt_rst_i),
    .src_sel_i  (rst_src_e'(src_sel_i)),
    .pol_low_i  (src_pol_low_i),
    .glob_q_o   (glob_q),
    .in_cfg_q_o (in_cfg_q),
    .abort_q_o  (abort_pulse_o),
    .pass_q_o   (pad_pass_o)
  );

  rst_cell_array #(.NCELL(NCELL), .GRP(GRP)) u_cells (
    .clk        (clk),
    .glob_q_i   (glob_q),
    .in_cfg_q_i (in_cfg_q),
    .set_mask_i (cell_set_mask_i),
    .optout_i   (grp_optout_i),
    .we_i       (cell_we_i),
    .d_i        (cell_d_i),
    .q_o        (cell_q_o)
  );

  assign glob_rst_o = glob_q;
endmodule

// File: rtl/chip_rst_chk.sv
module chip_rst_chk #(
  parameter int NCELL = 16,
  parameter int GRP   = 4,
  localparam int NGRP = NCELL / GRP
) (
  input logic             clk,
  input logic             por_i,
  input logic             cfg_busy_i,
  input logic             pad_rst_i,
  input logic             alt_rst_i,
  input logic [1:0]       src_sel_i,
  input logic             src_pol_low_i,
  input logic [NCELL-1:0] cell_set_mask_i,
  input logic [NGRP-1:0]  grp_optout_i,
  input logic [NCELL-1:0] cell_we_i,
  input logic [NCELL-1:0] cell_d_i,
  input logic             glob_rst_o,
  input logic             abort_pulse_o,
  input logic             pad_pass_o,
  input logic [NCELL-1:0] cell_q_o
);
  // R1
  p_cfg_forces_r1: assert property (@(posedge clk) disable iff (por_i)
    $past(cfg_busy_i) |-> glob_rst_o);
  // R1
  p_por_forces_r1: assert property (@(posedge clk) disable iff (por_i)
    $fell(por_i) |-> glob_rst_o);
  // R3
  p_none_quiet_r3: assert property (@(posedge clk) disable iff (por_i)
    (!$past(cfg_busy_i) && !$past(por_i) &&
     ($past(src_sel_i) == 2'd0 || $past(src_sel_i) == 2'd3)) |-> !glob_rst_o);
  // R2, R3
  p_alt_follow_r2: assert property (@(posedge clk) disable iff (por_i)
    (!$past(cfg_busy_i) && !$past(por_i) && $past(src_sel_i) == 2'd2)
      |-> (glob_rst_o == ($past(alt_rst_i) ^ $past(src_pol_low_i))));
  // R4
  p_cell_init_r4: assert property (@(posedge clk) disable iff (por_i)
    $past(cfg_busy_i, 2) |-> (cell_q_o == $past(cell_set_mask_i)));
  // R6
  p_abort_single_r6: assert property (@(posedge clk) disable iff (por_i)
    abort_pulse_o |=> !abort_pulse_o);
  // R6
  p_abort_in_cfg_r6: assert property (@(posedge clk) disable iff (por_i)
    abort_pulse_o |-> $past(cfg_busy_i));
  // R7
  p_pass_masked_r7: assert property (@(posedge clk) disable iff (por_i)
    ($past(src_sel_i) == 2'd1 || $past(cfg_busy_i)) |-> !pad_pass_o);
endmodule

bind chip_reset_dist chip_rst_chk #(.NCELL(NCELL), .GRP(GRP)) u_chk (.*);

// File: tb/sim_chip_reset_dist.sv
module sim_chip_reset_dist;
  localparam int NCELL = 16;
  localparam int GRP   = 4;
  localparam int NGRP  = NCELL / GRP;

  logic clk = 1'b0;
  logic por = 1'b1, cfg = 1'b0, pad = 1'b1, alt = 1'b1, pol = 1'b1;
  logic [1:0] sel = 2'd0;
  logic [NCELL-1:0] mask = '0, we = '0, d = '0;
  logic [NGRP-1:0] opt = '0;
  logic glob, abrt, pass;
  logic [NCELL-1:0] cq;

  int checks = 0, fails = 0;

  // cycle model state
  logic m_m = 1'b1, m_s = 1'b1, m_glob = 1'b1, m_incfg = 1'b1;
  logic m_abort = 1'b0, m_both = 1'b0, m_pass = 1'b0;
  logic [NCELL-1:0] m_cell = '0;
  logic model_on = 1'b0;

  always #10 clk = ~clk;

  chip_reset_dist #(.NCELL(NCELL), .GRP(GRP)) u0 (
    .clk(clk), .por_i(por), .cfg_busy_i(cfg), .pad_rst_i(pad), .alt_rst_i(alt),
    .src_sel_i(sel), .src_pol_low_i(pol), .cell_set_mask_i(mask),
    .grp_optout_i(opt), .cell_we_i(we), .cell_d_i(d),
    .glob_rst_o(glob), .abort_pulse_o(abrt), .pad_pass_o(pass), .cell_q_o(cq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic src_on(input logic lvl);
    return lvl ^ pol;
  endfunction

  task automatic model_step();
    logic pa, sa, cur;
    logic [NCELL-1:0] nc;
    pa = src_on(m_s);
    sa = (sel == 2'd1) ? pa : (sel == 2'd2) ? src_on(alt) : 1'b0;
    nc = m_cell;
    for (int i = 0; i < NCELL; i++) begin
      if (m_glob && (m_incfg || !opt[i / GRP])) nc[i] = mask[i];
      else if (we[i]) nc[i] = d[i];
    end
    m_cell = nc;
    if (por) begin
      m_m = pol; m_s = pol; m_glob = 1'b1; m_incfg = 1'b1;
      m_abort = 1'b0; m_both = 1'b0; m_pass = 1'b0;
    end else begin
      cur = cfg & pa;
      m_pass  = (sel != 2'd1 && !cfg) ? m_s : 1'b0;
      m_s     = m_m;
      m_m     = pad;
      m_glob  = cfg | sa;
      m_incfg = cfg;
      m_abort = cur & ~m_both;
      m_both  = cur;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    if (model_on) begin
      chk("R3 glob_rst_o vs model", 64'(glob), 64'(m_glob));
      chk("R4 cell_q_o vs model", 64'(cq), 64'(m_cell));
      chk("R7 pad_pass_o vs model", 64'(pass), 64'(m_pass));
      chk("R6 abort_pulse_o vs model", 64'(abrt), 64'(m_abort));
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    mask = 16'hA5C3;
    sel = 2'd2; alt = 1'b0; opt = '1;          // alternate asserted, all opted out
    repeat (3) step();
    chk("R1 reset forced during power-on", 64'(glob), 64'd1);
    chk("R4 cells take set mask at power-on (R5 opt-out ignored)", 64'(cq), 64'(mask));
    model_on = 1'b1;

    // configuration phase with pad assert -> abort
    por = 1'b0; cfg = 1'b1; alt = 1'b1; sel = 2'd0;
    step(); step();
    chk("R1 reset forced during configuration", 64'(glob), 64'd1);
    mask = 16'h0F0F; step();
    chk("R5 opt-out ignored during configuration", 64'(cq), 64'h0F0F);
    pad = 1'b0;                                  // asserted (active low)
    step(); chk("R6 no abort after 1 edge", 64'(abrt), 64'd0);
    step(); chk("R6 no abort after 2 edges", 64'(abrt), 64'd0);
    step(); chk("R6 abort pulse on 3rd edge", 64'(abrt), 64'd1);
    step(); chk("R6 abort only one cycle", 64'(abrt), 64'd0);
    chk("R1 pad during config stays forced", 64'(glob), 64'd1);
    pad = 1'b1; step(); step(); step();
    cfg = 1'b0; sel = 2'd1; opt = '0; step(); step();
    chk("R3 pad source idle gives no reset", 64'(glob), 64'd0);

    // R8 synchroniser depth
    pad = 1'b0;
    step(); chk("R8 pad not seen after 1 edge", 64'(glob), 64'd0);
    step(); chk("R8 pad not seen after 2 edges", 64'(glob), 64'd0);
    step(); chk("R8 pad reaches reset on 3rd edge", 64'(glob), 64'd1);
    pad = 1'b1; repeat (4) step();

    // R2 polarity on alternate
    sel = 2'd2; pol = 1'b0; alt = 1'b1; step();
    chk("R2 active-high alt=1 asserts", 64'(glob), 64'd1);
    alt = 1'b0; step();
    chk("R2 active-high alt=0 idle", 64'(glob), 64'd0);
    pol = 1'b1; step();
    chk("R2 active-low alt=0 asserts", 64'(glob), 64'd1);
    alt = 1'b1; step();

    // R5 opt-out after configuration
    d = 16'h3C96; we = '1; opt = 4'b0101; mask = 16'hFFFF; step();
    we = '0; alt = 1'b0; step(); step();
    chk("R5 opted-out groups keep data, others preset",
        64'(cq), 64'(16'h0F0F & 16'h3C96 | 16'hF0F0));
    alt = 1'b1; step();

    // R7 pass-through
    sel = 2'd0; pad = 1'b0; repeat (3) step();
    chk("R7 pad level passed when not selected", 64'(pass), 64'd0);
    pad = 1'b1; repeat (3) step();
    chk("R7 pad level passed high", 64'(pass), 64'd1);
    sel = 2'd1; step();
    chk("R7 pass masked when pad selected", 64'(pass), 64'd0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      sel  = 2'($urandom);
      pol  = ($urandom % 8) == 0 ? ~pol : pol;
      alt  = 1'($urandom);
      pad  = ($urandom % 3) == 0 ? ~pad : pad;
      opt  = NGRP'($urandom);
      mask = NCELL'($urandom);
      we   = NCELL'($urandom);
      d    = NCELL'($urandom);
      if (cfg) cfg = ($urandom % 6) != 0;
      else     cfg = ($urandom % 40) == 0;
      por  = ($urandom % 300) == 0;
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule